// File: doc/BRIEF.md
# Ethernet MAC Clock Generation Unit

This block derives the two clocks an Ethernet MAC needs towards its PHY from a pair of fast source clocks. One of the two sources is picked, divided by a programmable integer ratio to form an intermediate clock, and divided again by 5 or 10 to form the PHY reference clock. In RGMII operation the intermediate clock is the transmit clock and can be shifted late in quarter-period steps. In RMII operation the transmit clock is the reference clock, optionally inverted. A single global enable starts and stops both generators.

The block runs in one clock domain, `clk`, which is also the fast delay clock. Each source clock is represented by a tick input that is high for one `clk` cycle at every edge of that source, rising or falling. A source that ticks on every `clk` cycle therefore runs at half the `clk` rate. Software writes a 32-bit control word with a per-bit write mask. Outputs are levels that change only after a `clk` rising edge.

Control word fields: bit 0 selects the mode (1 = RGMII, 0 = RMII). Bit 4 selects the source (0 = A, 1 = B). Bits 6:5 hold the delay code. Bits 9:7 hold the ratio. Bit 10 selects the final divide (0 = 5, 1 = 10). Bit 11 is the RMII inversion. Bit 12 is the enable. All other bits are stored but have no effect.

Top module: `clkgen_top`

## Requirements
- R1: After reset the control word is zero, and both `tx_clk_o` and `ref_clk_o` are low.
- R2: On a cycle with `wr_en` high, each control bit whose `wr_mask` bit is 1 takes the value of `wr_data`, and every other bit keeps its value. The new word acts from the next cycle.
- R3: While bit 12 is 0, both outputs are low and the divider state is cleared. After bit 12 is set, the intermediate clock starts low from a zero count.
- R4: Bit 4 picks which tick input drives the divider: `src_a_tick` when 0, `src_b_tick` when 1. Ticks on the other input have no effect.
- R5: With ratio field N (bits 9:7) and divide factor max(N,1), the intermediate clock toggles once every max(N,1) selected ticks. A field value of 0 acts as a divide factor of 1.
- R6: The reference clock `ref_clk_o` toggles once every 5 intermediate-clock toggles when bit 10 is 0, and once every 10 when bit 10 is 1.
- R7: In RGMII mode (bit 0 = 1), `tx_clk_o` is the intermediate clock delayed by C `clk` cycles, where C is the effective delay code (0 to 3). With one tick per cycle and ratio 2, this is a delay of C quarter periods.
- R8: A new delay code from bits 6:5 becomes effective only in the cycle after the undelayed intermediate clock rises. Until then the previous code stays in force. While disabled, the effective code is 0.
- R9: In RMII mode (bit 0 = 0), `tx_clk_o` equals `ref_clk_o` XOR bit 11. The delay code has no effect, and a code captured at a rise in RMII mode is 0.
- R10: In RGMII mode, bit 11 has no effect on `tx_clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast delay clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_tick | input | 1 | Edge tick of source clock A |
| src_b_tick | input | 1 | Edge tick of source clock B |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write value |
| wr_mask | input | 32 | Per-bit write mask, 1 = update |
| tx_clk_o | output | 1 | Transmit clock to the MAC/PHY |
| ref_clk_o | output | 1 | PHY reference clock |

## Verification
On every cycle, the assertions check four things: masked-write retention of the control word, clearing of the divider state while disabled, the bound on intermediate toggles between reference toggles, and the rule that the effective delay code changes only just after a rise of the undelayed clock. Exact waveforms can only be shown by the bench scenarios, which compare both outputs on every cycle against a model. Those waveforms are the divide ratios including the zero case, the 5/10 selection, source selection with distinct tick patterns, each delay tap, the deferred code switch, RMII inversion, and the indifference to the inversion bit in RGMII mode.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int REG_W   = 32;
    localparam int RATIO_W = 3;
    localparam int DLY_W   = 2;

    localparam int BIT_MODE   = 0;
    localparam int BIT_SRC    = 4;
    localparam int LSB_DLY    = 5;
    localparam int LSB_RATIO  = 7;
    localparam int BIT_DIVHI  = 10;
    localparam int BIT_INV    = 11;
    localparam int BIT_ENABLE = 12;

    typedef struct packed {
        logic               enable;
        logic               rmii_inv;
        logic               div_hi;
        logic [RATIO_W-1:0] ratio;
        logic [DLY_W-1:0]   dly;
        logic               src_b;
        logic               rgmii;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.enable   = w[BIT_ENABLE];
        c.rmii_inv = w[BIT_INV];
        c.div_hi   = w[BIT_DIVHI];
        c.ratio    = w[LSB_RATIO +: RATIO_W];
        c.dly      = w[LSB_DLY +: DLY_W];
        c.src_b    = w[BIT_SRC];
        c.rgmii    = w[BIT_MODE];
        return c;
    endfunction

endpackage

// File: rtl/clkgen_ctrl_reg.sv
module clkgen_ctrl_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] ctrl_o
);

    typedef struct packed {
        logic [W-1:0] word;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.word = (state_q.word & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o = state_q.word;

endmodule

// File: rtl/clkgen_toggle_div.sv
module clkgen_toggle_div #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             lvl_o,
    output logic             tog_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } div_state_t;

    div_state_t state_d, state_q;
    logic [CNT_W-1:0] lim_m1;
    logic             wrap;
    logic             tog;

    always_comb begin
        lim_m1  = limit - 1'b1;
        wrap    = (state_q.cnt >= lim_m1);
        tog     = step && wrap && !clr;
        state_d = state_q;
        if (clr) begin
            state_d.cnt = '0;
            state_d.lvl = 1'b0;
        end else if (step) begin
            if (wrap) begin
                state_d.cnt = '0;
                state_d.lvl = ~state_q.lvl;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lvl_o = state_q.lvl;
    assign tog_o = tog;

endmodule

// File: rtl/clkgen_tx_delay.sv
module clkgen_tx_delay #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              apply_i,
    input  logic              lvl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              lvl_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int TAPS = 2 ** CODE_W;
    localparam int SH_W = TAPS - 1;

    typedef struct packed {
        logic [SH_W-1:0]   sh;
        logic [CODE_W-1:0] code;
    } dly_state_t;

    dly_state_t state_d, state_q;
    logic [TAPS-1:0] taps;
    logic            rise;

    always_comb begin
        taps    = {state_q.sh, lvl_i};
        rise    = lvl_i && !state_q.sh[0];
        state_d = state_q;
        state_d.sh = {state_q.sh[SH_W-2:0], lvl_i};
        if (clr) begin
            state_d.code = '0;
        end else if (rise) begin
            state_d.code = apply_i ? code_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lvl_o  = taps[state_q.code];
    assign code_o = state_q.code;

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int DIV_LO = 5,
    parameter int DIV_HI = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_a_tick,
    input  logic             src_b_tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] wr_mask,
    output logic             tx_clk_o,
    output logic             ref_clk_o
);

    localparam int FIN_W = $clog2(DIV_HI + 1);

    logic [REG_W-1:0]   ctrl_w;
    cfg_t               cfg;
    logic               sel_tick;
    logic [RATIO_W-1:0] ratio_lim;
    logic [FIN_W-1:0]   fin_lim;
    logic               div_clr;
    logic               mid_lvl, mid_tog;
    logic               ref_lvl, ref_tog;
    logic               dly_lvl;
    logic [DLY_W-1:0]   dly_code;

    clkgen_ctrl_reg #(.W(REG_W)) ctrl_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .ctrl_o  (ctrl_w)
    );

    always_comb begin
        cfg       = decode_cfg(ctrl_w);
        sel_tick  = cfg.src_b ? src_b_tick : src_a_tick;
        ratio_lim = (cfg.ratio == '0) ? RATIO_W'(1) : cfg.ratio;
        fin_lim   = cfg.div_hi ? FIN_W'(DIV_HI) : FIN_W'(DIV_LO);
        div_clr   = !cfg.enable;
    end

    clkgen_toggle_div #(.CNT_W(RATIO_W)) mid_div_u (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .step  (sel_tick),
        .limit (ratio_lim),
        .lvl_o (mid_lvl),
        .tog_o (mid_tog)
    );

    clkgen_toggle_div #(.CNT_W(FIN_W)) ref_div_u (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .step  (mid_tog),
        .limit (fin_lim),
        .lvl_o (ref_lvl),
        .tog_o (ref_tog)
    );

    clkgen_tx_delay #(.CODE_W(DLY_W)) dly_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (div_clr),
        .apply_i (cfg.rgmii),
        .lvl_i   (mid_lvl),
        .code_i  (cfg.dly),
        .lvl_o   (dly_lvl),
        .code_o  (dly_code)
    );

    always_comb begin
        if (!cfg.enable) begin
            tx_clk_o  = 1'b0;
            ref_clk_o = 1'b0;
        end else begin
            tx_clk_o  = cfg.rgmii ? dly_lvl : (ref_lvl ^ cfg.rmii_inv);
            ref_clk_o = ref_lvl;
        end
    end

endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker #(
    parameter int W      = 32,
    parameter int CODE_W = 2,
    parameter int DIV_HI = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [W-1:0]      wr_mask,
    input logic [W-1:0]      ctrl,
    input logic              en,
    input logic              mid,
    input logic              mid_tog,
    input logic              refl,
    input logic              ref_tog,
    input logic [CODE_W-1:0] code
);

    localparam int CW = $clog2(DIV_HI + 2);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (!en || ref_tog) begin
            since_q <= '0;
        end else if (mid_tog) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R2: unmasked bits keep their value
    a_r2_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl & ~$past(wr_mask)) == ($past(ctrl) & ~$past(wr_mask))));

    // R2: no write leaves the word unchanged
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

    // R3: disabled clears the divider levels
    a_r3_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mid && !refl));

    // R6: never more than DIV_HI intermediate toggles without a reference toggle
    a_r6_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mid_tog && !ref_tog) |-> (int'(since_q) + 1 < DIV_HI));

    // R6: reference level moves only together with the intermediate level
    a_r6_ref_with_mid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (refl != $past(refl))) |-> (mid != $past(mid)));

    // R8: effective delay code changes only right after a rise
    a_r8_code_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (code != $past(code))) |-> ($past(mid) && !$past(mid, 2)));

endmodule

bind clkgen_top clkgen_checker #(
    .W      (clkgen_pkg::REG_W),
    .CODE_W (clkgen_pkg::DLY_W),
    .DIV_HI (DIV_HI)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_mask (wr_mask),
    .ctrl    (ctrl_w),
    .en      (cfg.enable),
    .mid     (mid_lvl),
    .mid_tog (mid_tog),
    .refl    (ref_lvl),
    .ref_tog (ref_tog),
    .code    (dly_code)
);

// File: tb/clkgen_top_tb_top.sv
module clkgen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_a_tick = 1'b0;
    logic        src_b_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic        tx_clk_o, ref_clk_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] m_ctrl;
    int          m_cnt1, m_cnt2;
    logic        m_mid, m_ref;
    logic [2:0]  m_sh;
    logic [1:0]  m_dly;

    always #10 clk = ~clk;

    clkgen_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_a_tick (src_a_tick),
        .src_b_tick (src_b_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .tx_clk_o   (tx_clk_o),
        .ref_clk_o  (ref_clk_o)
    );

    function automatic logic exp_ref();
        return m_ctrl[12] & m_ref;
    endfunction

    function automatic logic exp_tx();
        logic [3:0] taps;
        taps = {m_sh, m_mid};
        if (!m_ctrl[12]) return 1'b0;
        if (m_ctrl[0]) return taps[m_dly];
        return m_ref ^ m_ctrl[11];
    endfunction

    task automatic model_step(input logic ta, input logic tb, input logic we,
                              input logic [31:0] d, input logic [31:0] m);
        logic en, tick, tog1, tog2, rise;
        int n, dv;
        en   = m_ctrl[12];
        tick = m_ctrl[4] ? tb : ta;
        n    = (m_ctrl[9:7] == 0) ? 1 : int'(m_ctrl[9:7]);
        dv   = m_ctrl[10] ? 10 : 5;
        tog1 = en && tick && (m_cnt1 >= n - 1);
        tog2 = tog1 && (m_cnt2 >= dv - 1);
        rise = m_mid && !m_sh[0];
        m_sh = {m_sh[1:0], m_mid};
        if (!en) begin
            m_cnt1 = 0; m_mid = 0; m_cnt2 = 0; m_ref = 0; m_dly = 0;
        end else begin
            if (tick) m_cnt1 = tog1 ? 0 : m_cnt1 + 1;
            if (tog1) begin
                m_mid  = ~m_mid;
                m_cnt2 = tog2 ? 0 : m_cnt2 + 1;
            end
            if (tog2) m_ref = ~m_ref;
            if (rise) m_dly = m_ctrl[0] ? m_ctrl[6:5] : 2'd0;
        end
        if (we) m_ctrl = (m_ctrl & ~m) | (d & m);
    endtask

    task automatic compare(input string tag);
        checks++;
        if (tx_clk_o !== exp_tx()) begin
            errors++;
            $display("FAIL %s cycle %0d tx_clk_o actual %b expected %b", tag, cyc, tx_clk_o, exp_tx());
        end
        checks++;
        if (ref_clk_o !== exp_ref()) begin
            errors++;
            $display("FAIL %s cycle %0d ref_clk_o actual %b expected %b", tag, cyc, ref_clk_o, exp_ref());
        end
    endtask

    // pat: 0 A every cycle, 1 A every cycle and B every other, 2 random, 3 B only
    task automatic cycle(input string tag, input int pat, input logic we,
                         input logic [31:0] d, input logic [31:0] m);
        logic ta, tb;
        @(negedge clk);
        cyc++;
        compare(tag);
        case (pat)
            0: begin ta = 1; tb = 0; end
            1: begin ta = 1; tb = cyc[0]; end
            3: begin ta = 0; tb = 1; end
            default: begin ta = 1'($urandom); tb = 1'($urandom); end
        endcase
        src_a_tick = ta; src_b_tick = tb;
        wr_en = we; wr_data = d; wr_mask = m;
        model_step(ta, tb, we, d, m);
    endtask

    task automatic run(input string tag, input int pat, input int n);
        for (int i = 0; i < n; i++) cycle(tag, pat, 1'b0, '0, '0);
    endtask

    task automatic wr_all(input string tag, input int pat, input logic [31:0] d);
        cycle(tag, pat, 1'b1, d, 32'hFFFF_FFFF);
    endtask

    function automatic logic [31:0] cfg_word(input bit en, input bit inv, input bit hi,
                                             input int ratio, input int dly,
                                             input bit srcb, input bit rgmii);
        logic [31:0] w;
        w = '0;
        w[12] = en; w[11] = inv; w[10] = hi;
        w[9:7] = 3'(ratio); w[6:5] = 2'(dly);
        w[4] = srcb; w[0] = rgmii;
        return w;
    endfunction

    initial begin
        int seed;
        seed = 32'h5eed_0123;
        void'($urandom(seed));
        m_ctrl = '0; m_cnt1 = 0; m_cnt2 = 0; m_mid = 0; m_ref = 0; m_sh = '0; m_dly = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, outputs low
        run("R1", 0, 4);

        // R3: ticks while disabled
        wr_all("R3", 0, cfg_word(0, 0, 0, 2, 1, 0, 1));
        run("R3", 0, 40);

        // R5: every ratio value including zero
        for (int r = 0; r < 8; r++) begin
            wr_all("R5", 0, cfg_word(1, 0, 0, r, 0, 0, 1));
            run("R5", 0, 60);
        end

        // R6: final stage divide by 10 and by 5
        wr_all("R6", 0, cfg_word(1, 0, 1, 1, 0, 0, 1));
        run("R6", 0, 80);
        wr_all("R6", 0, cfg_word(1, 0, 1, 3, 0, 0, 1));
        run("R6", 0, 120);
        wr_all("R6", 0, cfg_word(1, 0, 0, 1, 0, 0, 1));
        run("R6", 0, 60);

        // R4: source B selected, A ticks ignored; and A selected, B ticks ignored
        wr_all("R4", 1, cfg_word(1, 0, 0, 1, 0, 1, 1));
        run("R4", 1, 100);
        run("R4", 0, 40);
        wr_all("R4", 3, cfg_word(1, 0, 0, 1, 0, 0, 1));
        run("R4", 3, 40);

        // R7: each delay tap, ratio 2, tick every cycle
        for (int c = 0; c < 4; c++) begin
            wr_all("R7", 0, cfg_word(1, 0, 0, 2, c, 0, 1));
            run("R7", 0, 40);
        end

        // R8: code changed at arbitrary phases via masked writes to bits 6:5
        for (int k = 0; k < 12; k++) begin
            run("R8", 0, 1 + int'($urandom_range(0, 5)));
            cycle("R8", 0, 1'b1, {25'd0, 2'($urandom), 5'd0}, 32'h0000_0060);
        end
        run("R8", 0, 20);

        // R9: RMII with delay code set, inversion off and on
        wr_all("R9", 0, cfg_word(1, 0, 0, 2, 3, 0, 0));
        run("R9", 0, 80);
        wr_all("R9", 0, cfg_word(1, 1, 0, 2, 3, 0, 0));
        run("R9", 0, 80);

        // R10: RGMII with the inversion bit set
        wr_all("R10", 0, cfg_word(1, 1, 0, 2, 1, 0, 1));
        run("R10", 0, 60);

        // R2: masked write of all ones touching only bit 10
        cycle("R2", 0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0400);
        run("R2", 0, 80);
        // R2: random data under random masks
        for (int k = 0; k < 200; k++) begin
            cycle("R2", 2, 1'b1, $urandom, $urandom);
            run("R2", 2, 10);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule